// File: doc/BRIEF.md
# Buffered Crosspoint Switch with Round-Robin Output Polling

This block is a square switching fabric for best-effort traffic. Each input port carries a stream of words. The first word of a frame holds a destination tag, and the final word is marked as the frame end. Every input/output pair has its own small queue. A frame is written into the queue that sits at the crossing of its input row and its destination column. Because each column drains on its own, outputs that serve different inputs run at the same time and never block each other.

Each output port runs an independent round-robin poll over the queues in its column. When the output is idle and a polled queue holds a complete frame, the output takes that frame and stays busy until the frame-end word leaves. The frame goes out as one unbroken burst. The output then drops back to idle and the poll resumes at the next input after the one just served.

Each queue holds two maximum-length frames. A frame is checked on its first word. If the target queue cannot take a full maximum-length frame at that moment, the whole frame is discarded and the drop counter of that input is incremented.

Top module: `xbar_switch`

## Requirements
- R1: After reset, every `out_valid_o` bit is 0 and every `drop_cnt_o` field is 0.
- R2: The destination tag is read only on the first word of a frame, which is any word that arrives while that input is not inside a frame; tags on later words are ignored. A frame of up to MAX_WORDS words is delivered on the output named by that tag, with its words in order. `out_last_o` is high only on the final word.
- R3: Two outputs fed from different inputs can both present valid words in the same cycle.
- R4: An output starts a frame only when it is idle and the selected queue holds the complete frame. Once started, the frame's words appear on consecutive cycles with no gap and no words from any other input.
- R5: After an output serves input i, its next search starts at input (i+1) mod PORTS. After reset the search starts at input 0.
- R6: Each crosspoint queue holds 2*MAX_WORDS words. On a frame's first word, if the target queue has fewer than MAX_WORDS free entries, every word of that frame is discarded and that input's drop counter rises by exactly 1.
- R7: After the word with `out_last_o` high, the output is idle (`out_valid_o` low) for at least the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | PORTS | Word valid, one bit per input |
| in_data_i | input | PORTS*WORD_W | Input word, one field per input |
| in_dest_i | input | PORTS*DEST_W | Destination output index, read on the first word of a frame |
| in_last_i | input | PORTS | Frame-end marker, one bit per input |
| out_valid_o | output | PORTS | Output word valid, one bit per output |
| out_data_o | output | PORTS*WORD_W | Output word, one field per output |
| out_last_o | output | PORTS | Output frame-end marker |
| drop_cnt_o | output | PORTS*DROP_W | Per-input count of discarded frames, saturating |

## Verification
Several corner cases are targeted directly:

- **Ignored later tags.** A frame carries a wrong tag on every word after the first. A design that re-read the tag would scatter the frame's tail across other outputs.
- **Round-robin order.** All four inputs load the same output at once, two frames each. The delivered order must follow the rotation from the last-served input. A fixed-priority design would emit input 0 twice in a row.
- **Burst integrity.** The same run checks for gaps inside frames and for a frame starting straight after a frame end. Interleaving or a stuck busy flag would show up there.
- **Admission limit.** A single input sends three frames back to back while the output drains. The third frame meets only three free entries and must vanish whole with one count. A design that checked space word by word, or counted each word, would leak a partial frame or over-count.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int unsigned PORTS_DEF     = 4;
  localparam int unsigned WORD_W_DEF    = 16;
  localparam int unsigned MAX_WORDS_DEF = 4;
  localparam int unsigned DROP_W_DEF    = 8;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/xbar_xp_queue.sv
module xbar_xp_queue #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned MAX_WORDS = 4,
  localparam int unsigned DEPTH    = 2 * MAX_WORDS,
  localparam int unsigned AW       = xbar_pkg::idx_width(DEPTH),
  localparam int unsigned CW       = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              last_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] head_data_o,
  output logic              head_last_o,
  output logic [CW-1:0]     free_o,
  output logic              has_frame_o,
  output logic              nonempty_o
);
  logic [WORD_W:0] mem_q [DEPTH];
  logic [AW-1:0]   wr_q, rd_q;
  logic [CW-1:0]   count_q, frames_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= {last_i, data_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q     <= '0;
      rd_q     <= '0;
      count_q  <= '0;
      frames_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      unique case ({push_i, pop_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
      unique case ({push_i & last_i, pop_i & head_last_o})
        2'b10:   frames_q <= frames_q + 1'b1;
        2'b01:   frames_q <= frames_q - 1'b1;
        default: frames_q <= frames_q;
      endcase
    end
  end

  assign head_data_o = mem_q[rd_q][WORD_W-1:0];
  assign head_last_o = mem_q[rd_q][WORD_W];
  assign free_o      = CW'(DEPTH) - count_q;
  assign has_frame_o = (frames_q != '0);
  assign nonempty_o  = (count_q != '0);

  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (count_q < CW'(DEPTH)));
  // R4
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (count_q != '0));
endmodule

// File: rtl/xbar_in_port.sv
module xbar_in_port #(
  parameter int unsigned PORTS     = 4,
  parameter int unsigned MAX_WORDS = 4,
  parameter int unsigned CW        = 4,
  parameter int unsigned DROP_W    = 8,
  localparam int unsigned DEST_W   = xbar_pkg::idx_width(PORTS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic [DEST_W-1:0]         dest_i,
  input  logic                      last_i,
  input  logic [PORTS-1:0][CW-1:0]  free_row_i,
  output logic [PORTS-1:0]          push_o,
  output logic [DROP_W-1:0]         drop_cnt_o
);
  logic              in_frame_q, keep_q, keep_c;
  logic [DEST_W-1:0] dest_q, dest_c;

  always_comb begin
    dest_c = in_frame_q ? dest_q : dest_i;
    if (in_frame_q) keep_c = keep_q;
    else keep_c = (int'(dest_i) < PORTS) && (free_row_i[dest_i] >= CW'(MAX_WORDS));
    push_o = '0;
    if (valid_i && keep_c) push_o[dest_c] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      keep_q     <= 1'b0;
      dest_q     <= '0;
      drop_cnt_o <= '0;
    end else if (valid_i) begin
      if (!in_frame_q) begin
        dest_q <= dest_i;
        keep_q <= keep_c;
        if (!keep_c && (drop_cnt_o != '1)) drop_cnt_o <= drop_cnt_o + 1'b1;
      end
      in_frame_q <= !last_i;
    end
  end

  // R6
  drop_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_cnt_o != $past(drop_cnt_o)) |-> (drop_cnt_o == $past(drop_cnt_o) + 1'b1));
endmodule

// File: rtl/xbar_out_port.sv
module xbar_out_port #(
  parameter int unsigned PORTS   = 4,
  parameter int unsigned WORD_W  = 16,
  localparam int unsigned IW     = xbar_pkg::idx_width(PORTS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [PORTS-1:0]              has_frame_i,
  input  logic [PORTS-1:0]              head_ok_i,
  input  logic [PORTS-1:0][WORD_W-1:0]  head_data_i,
  input  logic [PORTS-1:0]              head_last_i,
  output logic [PORTS-1:0]              pop_o,
  output logic                          valid_o,
  output logic [WORD_W-1:0]             data_o,
  output logic                          last_o
);
  logic          busy_q, found;
  logic [IW-1:0] sel_q, ptr_q, pick;
  int            idx;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    idx   = 0;
    for (int k = 0; k < PORTS; k++) begin
      idx = (int'(ptr_q) + k) % PORTS;
      if (!found && has_frame_i[idx]) begin
        found = 1'b1;
        pick  = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sel_q  <= '0;
      ptr_q  <= '0;
    end else if (!busy_q) begin
      if (found) begin
        busy_q <= 1'b1;
        sel_q  <= pick;
        ptr_q  <= (pick == IW'(PORTS - 1)) ? '0 : pick + 1'b1;
      end
    end else if (head_last_i[sel_q]) begin
      busy_q <= 1'b0;
    end
  end

  always_comb begin
    pop_o = '0;
    if (busy_q) pop_o[sel_q] = 1'b1;
  end

  assign valid_o = busy_q;
  assign data_o  = head_data_i[sel_q];
  assign last_o  = busy_q & head_last_i[sel_q];

  // R4
  busy_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> head_ok_i[sel_q]);
  // R7
  idle_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !valid_o);
endmodule

// File: rtl/xbar_switch.sv
module xbar_switch #(
  parameter int unsigned PORTS     = xbar_pkg::PORTS_DEF,
  parameter int unsigned WORD_W    = xbar_pkg::WORD_W_DEF,
  parameter int unsigned MAX_WORDS = xbar_pkg::MAX_WORDS_DEF,
  parameter int unsigned DROP_W    = xbar_pkg::DROP_W_DEF,
  localparam int unsigned DEST_W   = xbar_pkg::idx_width(PORTS),
  localparam int unsigned CW       = $clog2(2 * MAX_WORDS + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [PORTS-1:0]              in_valid_i,
  input  logic [PORTS-1:0][WORD_W-1:0]  in_data_i,
  input  logic [PORTS-1:0][DEST_W-1:0]  in_dest_i,
  input  logic [PORTS-1:0]              in_last_i,
  output logic [PORTS-1:0]              out_valid_o,
  output logic [PORTS-1:0][WORD_W-1:0]  out_data_o,
  output logic [PORTS-1:0]              out_last_o,
  output logic [PORTS-1:0][DROP_W-1:0]  drop_cnt_o
);
  // [input][output] unless named _col, which is [output][input]
  logic [PORTS-1:0][PORTS-1:0]             push_m;
  logic [PORTS-1:0][PORTS-1:0][CW-1:0]     free_m;
  logic [PORTS-1:0][PORTS-1:0]             pop_col, frame_col, ok_col, last_col;
  logic [PORTS-1:0][PORTS-1:0][WORD_W-1:0] data_col;

  for (genvar i = 0; i < PORTS; i++) begin : g_in
    xbar_in_port #(
      .PORTS(PORTS), .MAX_WORDS(MAX_WORDS), .CW(CW), .DROP_W(DROP_W)
    ) u_in (
      .clk_i, .rst_ni,
      .valid_i   (in_valid_i[i]),
      .dest_i    (in_dest_i[i]),
      .last_i    (in_last_i[i]),
      .free_row_i(free_m[i]),
      .push_o    (push_m[i]),
      .drop_cnt_o(drop_cnt_o[i])
    );

    for (genvar j = 0; j < PORTS; j++) begin : g_xp
      xbar_xp_queue #(.WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS)) u_q (
        .clk_i, .rst_ni,
        .push_i     (push_m[i][j]),
        .data_i     (in_data_i[i]),
        .last_i     (in_last_i[i]),
        .pop_i      (pop_col[j][i]),
        .head_data_o(data_col[j][i]),
        .head_last_o(last_col[j][i]),
        .free_o     (free_m[i][j]),
        .has_frame_o(frame_col[j][i]),
        .nonempty_o (ok_col[j][i])
      );
    end
  end

  for (genvar j = 0; j < PORTS; j++) begin : g_out
    xbar_out_port #(.PORTS(PORTS), .WORD_W(WORD_W)) u_out (
      .clk_i, .rst_ni,
      .has_frame_i(frame_col[j]),
      .head_ok_i  (ok_col[j]),
      .head_data_i(data_col[j]),
      .head_last_i(last_col[j]),
      .pop_o      (pop_col[j]),
      .valid_o    (out_valid_o[j]),
      .data_o     (out_data_o[j]),
      .last_o     (out_last_o[j])
    );
  end
endmodule

// File: tb/xbar_switch_bench.sv
module xbar_switch_bench;
  localparam int P = 4;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [P-1:0]        in_valid = '0;
  logic [P-1:0][W-1:0] in_data = '0;
  logic [P-1:0][1:0]   in_dest = '0;
  logic [P-1:0]        in_last = '0;
  logic [P-1:0]        out_valid, out_last;
  logic [P-1:0][W-1:0] out_data;
  logic [P-1:0][7:0]   drop_cnt;

  always #5 clk = ~clk;

  xbar_switch u_xbar_switch (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_dest_i(in_dest), .in_last_i(in_last),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_last_o(out_last),
    .drop_cnt_o(drop_cnt)
  );

  int checks = 0, fails = 0;
  logic [W-1:0] rec_d [P][64];
  logic         rec_l [P][64];
  int  rcnt [P];
  int  gap_err = 0, idle_err = 0;
  bit  both_seen = 0;
  bit  in_pkt [P];
  bit  prev_last [P];
  bit  finished = 0;

  initial for (int j = 0; j < P; j++) begin
    rcnt[j] = 0; in_pkt[j] = 0; prev_last[j] = 0;
  end

  always @(negedge clk) if (rst_n) begin
    if (out_valid[0] && out_valid[1]) both_seen = 1;
    for (int j = 0; j < P; j++) begin
      if (in_pkt[j] && !out_valid[j]) gap_err++;
      if (prev_last[j] && out_valid[j]) idle_err++;
      if (out_valid[j] && rcnt[j] < 64) begin
        rec_d[j][rcnt[j]] = out_data[j];
        rec_l[j][rcnt[j]] = out_last[j];
        rcnt[j]++;
      end
      in_pkt[j]    = out_valid[j] && !out_last[j];
      prev_last[j] = out_valid[j] && out_last[j];
    end
  end

  function automatic logic [W-1:0] word_of(int src, int fid, int w);
    return {4'(src), 4'(fid), 8'(w)};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_rec();
    for (int j = 0; j < P; j++) rcnt[j] = 0;
    gap_err = 0; idle_err = 0; both_seen = 0;
  endtask

  // frames back to back; tags after the first word are deliberately wrong
  task automatic send_burst(int src, int dst, int fid0, int nfr, int len);
    for (int f = 0; f < nfr; f++)
      for (int w = 0; w < len; w++) begin
        @(negedge clk);
        in_valid[src] = 1'b1;
        in_data[src]  = word_of(src, fid0 + f, w);
        in_dest[src]  = (w == 0) ? 2'(dst) : 2'(dst + 1);
        in_last[src]  = (w == len - 1);
      end
    @(negedge clk);
    in_valid[src] = 1'b0;
    in_last[src]  = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // compare a recorded frame on output j at position pos
  task automatic check_frame(int j, int pos, int src, int fid, int len, string req);
    int bad = 0;
    for (int w = 0; w < len; w++) begin
      if (rec_d[j][pos + w] !== word_of(src, fid, w)) bad++;
      if (rec_l[j][pos + w] !== (w == len - 1)) bad++;
    end
    check(bad == 0, req, int'(rec_d[j][pos]), int'(word_of(src, fid, 0)));
  endtask

  task automatic t_reset();
    // R1
    check(out_valid == '0, "R1 out_valid", int'(out_valid), 0);
    check(drop_cnt == '0, "R1 drop_cnt", int'(drop_cnt), 0);
  endtask

  task automatic t_single();
    clear_rec();
    send_burst(2, 3, 1, 1, 3);
    wait_cyc(10);
    // R2
    check(rcnt[3] == 3, "R2 word count", rcnt[3], 3);
    check_frame(3, 0, 2, 1, 3, "R2 frame content");
    check(rcnt[0] + rcnt[1] + rcnt[2] == 0, "R2 stray words", rcnt[0] + rcnt[1] + rcnt[2], 0);
  endtask

  task automatic t_parallel();
    clear_rec();
    fork
      send_burst(0, 1, 2, 1, 4);
      send_burst(1, 0, 3, 1, 4);
    join
    wait_cyc(10);
    // R3
    check(both_seen, "R3 concurrent outputs", int'(both_seen), 1);
    check_frame(1, 0, 0, 2, 4, "R3 out1 data");
    check_frame(0, 0, 1, 3, 4, "R3 out0 data");
  endtask

  task automatic t_round_robin();
    int order [4] = '{2, 3, 0, 1};  // out0 last served input 1 in t_parallel
    clear_rec();
    fork
      send_burst(0, 0, 4, 2, 4);
      send_burst(1, 0, 4, 2, 4);
      send_burst(2, 0, 4, 2, 4);
      send_burst(3, 0, 4, 2, 4);
    join
    wait_cyc(60);
    // R5
    check(rcnt[0] == 32, "R5 total words", rcnt[0], 32);
    for (int k = 0; k < 8; k++)
      check_frame(0, 4 * k, order[k % 4], 4 + k / 4, 4, "R5 rotation order");
    // R4
    check(gap_err == 0, "R4 gap inside frame", gap_err, 0);
    // R7
    check(idle_err == 0, "R7 idle after last", idle_err, 0);
    check(drop_cnt == '0, "R6 no drop within capacity", int'(drop_cnt), 0);
  endtask

  task automatic t_drop();
    clear_rec();
    // third frame finds 3 free entries and is discarded
    send_burst(0, 2, 8, 3, 4);
    wait_cyc(20);
    // R6
    check(rcnt[2] == 8, "R6 delivered words", rcnt[2], 8);
    check_frame(2, 0, 0, 8, 4, "R6 first frame");
    check_frame(2, 4, 0, 9, 4, "R6 second frame");
    check(drop_cnt[0] == 8'd1, "R6 drop count", int'(drop_cnt[0]), 1);
    send_burst(0, 2, 12, 1, 4);
    wait_cyc(12);
    check(rcnt[2] == 12, "R6 later frame accepted", rcnt[2], 12);
    check_frame(2, 8, 0, 12, 4, "R6 later frame data");
    check(drop_cnt[0] == 8'd1, "R6 count unchanged", int'(drop_cnt[0]), 1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_single();
    t_parallel();
    t_round_robin();
    t_drop();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule